// File: doc/BRIEF.md
# Auxiliary System Control Registers

This block is a small bank of control registers for a workstation I/O companion chip. Software reaches it over a simple register bus: a request strobe, a write flag, a register select, byte enables and write data. A read returns the selected register one clock later on a read-data port with its own valid flag. Five of the registers are one byte wide and take only single-byte accesses on byte lane 0. They are: a configuration register, a diagnostic scratch register, a modem-control register, an auxiliary register that fires a floppy terminal-count pulse, and a power-down register. The sixth is a 32-bit system-control register that takes only full-word accesses.

The power-down register holds a power-fail status flag. The flag follows a power-failing input whenever that input changes, but it can only be set while the enable bit in the configuration register is on. It drives an interrupt output, and software clears it by writing a one to a clear bit. Writing the power-off bit sends a one-cycle shutdown request. Writing the system-control register with its low bit set sends a one-cycle system reset request and leaves a reset-status value in the register.

There are two resets. The power-on reset clears everything. The soft block reset clears the configuration, modem-control, auxiliary, power-down and flag state, and leaves the diagnostic and system-control registers as they were. Software can therefore see after a soft reset that a reset request came before it.

Top module: `aux_sysctl_regs`

## Requirements
- R1: A write reaches a byte register (selects 0 to 4) only when the byte enables are 4'b0001, and it takes its data from bits 7:0. It reaches the system-control register (select 5) only when the enables are 4'b1111. Any other enable pattern changes no state and produces no pulse.
- R2: The selects are: 0 configuration, 1 diagnostic, 2 modem control, 3 auxiliary, 4 power-down, 5 system control. The configuration, diagnostic and modem-control registers store the written byte. A read raises rd_valid for one cycle on the next clock, with the value the register held when the read was issued, zero-extended. Selects 6 and 7 read as zero.
- R3: Each change of pwr_fail_i sets the power-fail flag (power-down bit 5) to 1 when the input is now high and configuration bit 3 is set, and to 0 otherwise. Without a change the flag holds.
- R4: irq_o is high exactly when the flag and configuration bit 3 are both set. It follows a configuration write, a power-down write or an input change on the next clock.
- R5: A power-down write stores only data bits 1:0. Bit 5 of the write data has no effect on the flag. A one in bit 1 clears the flag, but if pwr_fail_i changes in the same cycle, the input update decides the flag.
- R6: An auxiliary-register write with data bit 1 set drives tc_pulse_o high for exactly the next cycle. Bit 1 always reads back as 0 and the other bits are stored.
- R7: A power-down write with data bit 0 set drives shutdown_req_o high for exactly the next cycle.
- R8: A system-control write with bit 0 set loads the register with 0x00000002 and drives reset_req_o high for exactly the next cycle. A write with bit 0 clear leaves the register unchanged and sends no request.
- R9: A low rst_n, sampled on a clock edge, clears the configuration, modem-control, auxiliary and power-down registers and the flag. It keeps the diagnostic and system-control values. A low por_n clears every register at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Soft block reset, synchronous, active low |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register select |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 32 | Read data |
| pwr_fail_i | input | 1 | Power-failing level input |
| irq_o | output | 1 | Power-fail interrupt |
| tc_pulse_o | output | 1 | Floppy terminal-count pulse |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
Two actions can both update the power-fail flag in the same cycle: a power-down write carrying the clear bit, and a change on pwr_fail_i. The bench drives the input high in the same cycle as a clear write while the enable is on. It then reads the power-down register and expects 0x22, with irq_o high, because the input update takes priority. A behavioural model, advanced on every clock, also judges every other clear, enable change and input edge against all outputs.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CFG  = 3'd0,
    SEL_DIAG = 3'd1,
    SEL_MDM  = 3'd2,
    SEL_AUX  = 3'd3,
    SEL_PWR  = 3'd4,
    SEL_SYS  = 3'd5
  } reg_sel_e;

  localparam int NUM_REGS      = 6;
  localparam int CFG_PFEN_BIT  = 3;
  localparam int PWR_OFF_BIT   = 0;
  localparam int PWR_CLR_BIT   = 1;
  localparam int PWR_FLAG_BIT  = 5;
  localparam int AUX_TC_BIT    = 1;
  localparam int SYS_RST_BIT   = 0;
  localparam int SYS_STATUS_VAL = 2;
endpackage

// File: rtl/aux_bus_decode.sv
module aux_bus_decode #(
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 3,
  parameter int NUM_REGS = 6,
  parameter int FULL_IDX = 5
) (
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [SEL_W-1:0]      req_sel,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic [NUM_REGS-1:0]   wr_stb,
  output logic                  rd_stb
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [BE_W-1:0] BE_BYTE = BE_W'(1);
  localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

  // one write strobe per register; access size picks the legal enable pattern
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [BE_W-1:0] NEED = (i == FULL_IDX) ? BE_FULL : BE_BYTE;
    assign wr_stb[i] = req_valid && req_write &&
                       (req_sel == SEL_W'(i)) && (req_be == NEED);
  end

  assign rd_stb = req_valid && !req_write;
endmodule

// File: rtl/aux_byte_reg.sv
module aux_byte_reg #(
  parameter int               BYTE_W    = 8,
  parameter logic [BYTE_W-1:0] KEEP_MASK = {BYTE_W{1'b1}},
  parameter bit               SOFT_CLR  = 1'b1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 q <= '0;
    else if (SOFT_CLR && !rst_n) q <= '0;
    else if (we)                q <= wdata & KEEP_MASK;
  end
endmodule

// File: rtl/aux_pwrfail_unit.sv
module aux_pwrfail_unit (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       pf_i,
  input  logic       pf_en,
  input  logic       we,
  input  logic [1:0] ctl_bits,
  output logic       flag_o,
  output logic [1:0] ctl_q,
  output logic       irq_o,
  output logic       shutdown_o
);
  import aux_sysctl_pkg::*;

  logic pf_prev;
  logic pf_edge;
  logic flag_d;

  assign pf_edge = pf_i ^ pf_prev;

  always_comb begin
    flag_d = flag_o;
    if (we && ctl_bits[PWR_CLR_BIT]) flag_d = 1'b0;
    // an input change is applied last and so wins over a clear
    if (pf_edge) flag_d = pf_i && pf_en;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pf_prev    <= 1'b0;
      flag_o     <= 1'b0;
      ctl_q      <= '0;
      shutdown_o <= 1'b0;
    end else if (!rst_n) begin
      pf_prev    <= 1'b0;
      flag_o     <= 1'b0;
      ctl_q      <= '0;
      shutdown_o <= 1'b0;
    end else begin
      pf_prev    <= pf_i;
      flag_o     <= flag_d;
      shutdown_o <= we && ctl_bits[PWR_OFF_BIT];
      if (we) ctl_q <= ctl_bits;
    end
  end

  assign irq_o = flag_o && pf_en;
endmodule

// File: rtl/aux_sysctl_unit.sv
module aux_sysctl_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              we,
  input  logic              rst_bit,
  output logic [DATA_W-1:0] q,
  output logic              rst_req_o
);
  import aux_sysctl_pkg::*;
  localparam logic [DATA_W-1:0] STATUS = DATA_W'(SYS_STATUS_VAL);

  // register content survives the soft reset; only the pulse is cleared
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      q         <= '0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= rst_n && we && rst_bit;
      if (rst_n && we && rst_bit) q <= STATUS;
    end
  end
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                pwr_fail_i,
  output logic                irq_o,
  output logic                tc_pulse_o,
  output logic                shutdown_req_o,
  output logic                reset_req_o
);
  import aux_sysctl_pkg::*;

  localparam logic [BYTE_W-1:0] AUX_MASK = ~(BYTE_W'(1) << AUX_TC_BIT);

  logic [NUM_REGS-1:0] wr_stb;
  logic                rd_stb;
  logic [BYTE_W-1:0]   wbyte;
  logic [BYTE_W-1:0]   cfg_q, diag_q, mdm_q, aux_q;
  logic [1:0]          pwr_ctl;
  logic                pf_flag;
  logic                pf_en;
  logic [DATA_W-1:0]   sys_q;
  logic [BYTE_W-1:0]   pwr_view;
  logic [DATA_W-1:0]   rd_mux;
  logic                unused_wdata_hi;

  assign wbyte           = req_wdata[BYTE_W-1:0];
  assign unused_wdata_hi = ^req_wdata[DATA_W-1:BYTE_W];
  assign pf_en           = cfg_q[CFG_PFEN_BIT];

  aux_bus_decode #(
    .DATA_W(DATA_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS), .FULL_IDX(int'(SEL_SYS))
  ) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_sel(req_sel),
    .req_be(req_be), .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  aux_byte_reg #(.BYTE_W(BYTE_W), .SOFT_CLR(1'b1)) u_cfg (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(wr_stb[SEL_CFG]),
    .wdata(wbyte), .q(cfg_q)
  );

  aux_byte_reg #(.BYTE_W(BYTE_W), .SOFT_CLR(1'b0)) u_diag (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(wr_stb[SEL_DIAG]),
    .wdata(wbyte), .q(diag_q)
  );

  aux_byte_reg #(.BYTE_W(BYTE_W), .SOFT_CLR(1'b1)) u_mdm (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(wr_stb[SEL_MDM]),
    .wdata(wbyte), .q(mdm_q)
  );

  aux_byte_reg #(.BYTE_W(BYTE_W), .KEEP_MASK(AUX_MASK), .SOFT_CLR(1'b1)) u_aux (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(wr_stb[SEL_AUX]),
    .wdata(wbyte), .q(aux_q)
  );

  // terminal-count strobe: one clock after the qualifying write
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      tc_pulse_o <= 1'b0;
    else if (!rst_n) tc_pulse_o <= 1'b0;
    else             tc_pulse_o <= wr_stb[SEL_AUX] && wbyte[AUX_TC_BIT];
  end

  aux_pwrfail_unit u_pwr (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .pf_i(pwr_fail_i), .pf_en(pf_en),
    .we(wr_stb[SEL_PWR]), .ctl_bits(wbyte[1:0]), .flag_o(pf_flag),
    .ctl_q(pwr_ctl), .irq_o(irq_o), .shutdown_o(shutdown_req_o)
  );

  aux_sysctl_unit #(.DATA_W(DATA_W)) u_sys (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .we(wr_stb[SEL_SYS]),
    .rst_bit(req_wdata[SYS_RST_BIT]), .q(sys_q), .rst_req_o(reset_req_o)
  );

  always_comb begin
    pwr_view               = '0;
    pwr_view[1:0]          = pwr_ctl;
    pwr_view[PWR_FLAG_BIT] = pf_flag;
  end

  always_comb begin
    case (req_sel)
      SEL_CFG:  rd_mux = DATA_W'(cfg_q);
      SEL_DIAG: rd_mux = DATA_W'(diag_q);
      SEL_MDM:  rd_mux = DATA_W'(mdm_q);
      SEL_AUX:  rd_mux = DATA_W'(aux_q);
      SEL_PWR:  rd_mux = DATA_W'(pwr_view);
      SEL_SYS:  rd_mux = sys_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      rd_data  <= rd_stb ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/aux_sysctl_regs_chk.sv
module aux_sysctl_regs_chk #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input logic                clk,
  input logic                por_n,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [SEL_W-1:0]    req_sel,
  input logic [DATA_W/8-1:0] req_be,
  input logic [DATA_W-1:0]   req_wdata,
  input logic                pwr_fail_i,
  input logic                irq_o,
  input logic                tc_pulse_o,
  input logic                shutdown_req_o,
  input logic                reset_req_o,
  input logic                pf_flag,
  input logic                pf_en,
  input logic [DATA_W-1:0]   sys_q
);
  localparam logic [DATA_W/8-1:0] BE_ONE  = (DATA_W/8)'(1);
  localparam logic [DATA_W/8-1:0] BE_ALL  = '1;

  logic wr_aux, wr_pwr, wr_sys, wr_cfg;
  assign wr_cfg = req_valid && req_write && req_sel == SEL_W'(0) && req_be == BE_ONE;
  assign wr_aux = req_valid && req_write && req_sel == SEL_W'(3) && req_be == BE_ONE;
  assign wr_pwr = req_valid && req_write && req_sel == SEL_W'(4) && req_be == BE_ONE;
  assign wr_sys = req_valid && req_write && req_sel == SEL_W'(5) && req_be == BE_ALL;

  assert_tc_source_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    tc_pulse_o |-> $past(wr_aux && req_wdata[1]));

  assert_shutdown_source_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    shutdown_req_o |-> $past(wr_pwr && req_wdata[0]));

  assert_reset_req_source_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reset_req_o |-> ($past(wr_sys && req_wdata[0]) && sys_q == DATA_W'(2)));

  assert_sys_hold_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_sys && !req_wdata[0]) |=> $stable(sys_q));

  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(pf_flag) |-> ($past(pwr_fail_i) && $past(pf_en)));

  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    $rose(irq_o) |-> ($rose(pf_flag) || $past(wr_cfg)));

  assert_flag_write_ignored_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (wr_pwr && !req_wdata[1] && pwr_fail_i == $past(pwr_fail_i)) |=> $stable(pf_flag));
endmodule

bind aux_sysctl_regs aux_sysctl_regs_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
  .req_write(req_write), .req_sel(req_sel), .req_be(req_be), .req_wdata(req_wdata),
  .pwr_fail_i(pwr_fail_i), .irq_o(irq_o), .tc_pulse_o(tc_pulse_o),
  .shutdown_req_o(shutdown_req_o), .reset_req_o(reset_req_o),
  .pf_flag(pf_flag), .pf_en(pf_en), .sys_q(sys_q)
);

// File: tb/aux_sysctl_regs_test.sv
module aux_sysctl_regs_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_sel = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        pwr_fail_i = 1'b0;
  logic        irq_o, tc_pulse_o, shutdown_req_o, reset_req_o;

  int total = 0;
  int bad = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  aux_sysctl_regs uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
    .req_write(req_write), .req_sel(req_sel), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .pwr_fail_i(pwr_fail_i), .irq_o(irq_o), .tc_pulse_o(tc_pulse_o),
    .shutdown_req_o(shutdown_req_o), .reset_req_o(reset_req_o)
  );

  // behavioural reference, advanced every clock
  logic [7:0]  m_cfg, m_diag, m_mdm, m_aux;
  logic [1:0]  m_ctl;
  logic        m_flag, m_prev, m_tc, m_sd, m_rr, m_rdv;
  logic [31:0] m_sys, m_rdd;

  function automatic logic [31:0] m_view(input logic [2:0] s);
    case (s)
      3'd0: return {24'h0, m_cfg};
      3'd1: return {24'h0, m_diag};
      3'd2: return {24'h0, m_mdm};
      3'd3: return {24'h0, m_aux};
      3'd4: return {26'h0, m_flag, 3'b000, m_ctl};
      3'd5: return m_sys;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_cfg = 0; m_diag = 0; m_mdm = 0; m_aux = 0; m_ctl = 0; m_flag = 0;
      m_prev = 0; m_tc = 0; m_sd = 0; m_rr = 0; m_rdv = 0; m_rdd = 0; m_sys = 0;
    end else if (!rst_n) begin
      m_cfg = 0; m_mdm = 0; m_aux = 0; m_ctl = 0; m_flag = 0;
      m_prev = 0; m_tc = 0; m_sd = 0; m_rr = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      bit wr, bok, fok, chg;
      logic en_old;
      wr  = req_valid && req_write;
      bok = (req_be == 4'b0001);
      fok = (req_be == 4'b1111);
      chg = (pwr_fail_i != m_prev);
      en_old = m_cfg[3];
      m_rdv = req_valid && !req_write;
      m_rdd = m_rdv ? m_view(req_sel) : 32'h0;
      m_tc = wr && bok && req_sel == 3'd3 && req_wdata[1];
      m_sd = wr && bok && req_sel == 3'd4 && req_wdata[0];
      m_rr = wr && fok && req_sel == 3'd5 && req_wdata[0];
      if (wr && bok && req_sel == 3'd4 && req_wdata[1]) m_flag = 1'b0;
      if (chg) m_flag = pwr_fail_i && en_old;
      m_prev = pwr_fail_i;
      if (wr && bok) begin
        case (req_sel)
          3'd0: m_cfg = req_wdata[7:0];
          3'd1: m_diag = req_wdata[7:0];
          3'd2: m_mdm = req_wdata[7:0];
          3'd3: m_aux = req_wdata[7:0] & 8'hFD;
          3'd4: m_ctl = req_wdata[1:0];
          default: ;
        endcase
      end
      if (m_rr) m_sys = 32'h2;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R4 model irq", {31'h0, irq_o}, {31'h0, m_flag & m_cfg[3]});
      chk("R6 model tc", {31'h0, tc_pulse_o}, {31'h0, m_tc});
      chk("R7 model shutdown", {31'h0, shutdown_req_o}, {31'h0, m_sd});
      chk("R8 model reset_req", {31'h0, reset_req_o}, {31'h0, m_rr});
      chk("R2 model rd_valid", {31'h0, rd_valid}, {31'h0, m_rdv});
      chk("R2 model rd_data", rd_data, m_rdd);
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] s, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = s; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 0; req_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = s; req_be = 4'b0001;
    @(negedge clk);
    req_valid = 0; req_be = 0;
    chk(tag, {31'h0, rd_valid}, 32'h1);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    idle(3);
    por_n = 1; rst_n = 1;
    started = 1;
    // R9 power-on state, R2 unused selects
    rd(3'd0, 32'h0, "R9 por cfg");
    rd(3'd1, 32'h0, "R9 por diag");
    rd(3'd5, 32'h0, "R9 por sys");
    rd(3'd7, 32'h0, "R2 unused select");
    // R2 plain storage
    wr(3'd0, 4'b0001, 32'h0000_0051);
    wr(3'd1, 4'b0001, 32'h1234_56C3);
    wr(3'd2, 4'b0001, 32'h0000_007E);
    rd(3'd0, 32'h51, "R2 cfg");
    rd(3'd1, 32'hC3, "R2 diag");
    rd(3'd2, 32'h7E, "R2 mdm");
    // R1 illegal access sizes
    wr(3'd1, 4'b0010, 32'h0000_AA00);
    rd(3'd1, 32'hC3, "R1 diag lane1 ignored");
    wr(3'd5, 4'b0001, 32'h1);
    chk("R1 sys byte write no request", {31'h0, reset_req_o}, 32'h0);
    rd(3'd5, 32'h0, "R1 sys byte write ignored");
    wr(3'd3, 4'b0011, 32'hFF);
    chk("R1 aux two-lane no pulse", {31'h0, tc_pulse_o}, 32'h0);
    // R6 terminal count
    wr(3'd3, 4'b0001, 32'hFF);
    chk("R6 tc pulse", {31'h0, tc_pulse_o}, 32'h1);
    idle(1);
    chk("R6 tc one cycle", {31'h0, tc_pulse_o}, 32'h0);
    rd(3'd3, 32'hFD, "R6 aux readback");
    // R3 disabled input change
    @(negedge clk); pwr_fail_i = 1;
    idle(2);
    rd(3'd4, 32'h0, "R3 flag blocked by enable");
    @(negedge clk); pwr_fail_i = 0;
    wr(3'd0, 4'b0001, 32'h59);
    @(negedge clk); pwr_fail_i = 1;
    @(negedge clk);
    chk("R4 irq raised", {31'h0, irq_o}, 32'h1);
    rd(3'd4, 32'h20, "R3 flag set");
    wr(3'd0, 4'b0001, 32'h51);
    chk("R4 irq off with enable", {31'h0, irq_o}, 32'h0);
    rd(3'd4, 32'h20, "R4 flag kept");
    wr(3'd0, 4'b0001, 32'h59);
    chk("R4 irq back", {31'h0, irq_o}, 32'h1);
    // R5 clear and ignored bit 5
    wr(3'd4, 4'b0001, 32'h02);
    chk("R5 irq cleared", {31'h0, irq_o}, 32'h0);
    rd(3'd4, 32'h02, "R5 clear");
    wr(3'd4, 4'b0001, 32'h20);
    rd(3'd4, 32'h00, "R5 bit5 write ignored");
    // R5 clear and input rise in one cycle
    @(negedge clk); pwr_fail_i = 0;
    idle(1);
    @(negedge clk);
    pwr_fail_i = 1;
    req_valid = 1; req_write = 1; req_sel = 3'd4; req_be = 4'b0001; req_wdata = 32'h02;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 0; req_wdata = 0;
    chk("R5 same-cycle irq", {31'h0, irq_o}, 32'h1);
    rd(3'd4, 32'h22, "R5 input wins over clear");
    @(negedge clk); pwr_fail_i = 0;
    @(negedge clk);
    chk("R3 fall clears irq", {31'h0, irq_o}, 32'h0);
    // R7 shutdown
    wr(3'd4, 4'b0001, 32'h01);
    chk("R7 shutdown pulse", {31'h0, shutdown_req_o}, 32'h1);
    idle(1);
    chk("R7 shutdown one cycle", {31'h0, shutdown_req_o}, 32'h0);
    // R8 system control
    wr(3'd5, 4'b1111, 32'h0);
    chk("R8 no request", {31'h0, reset_req_o}, 32'h0);
    rd(3'd5, 32'h0, "R8 unchanged");
    wr(3'd5, 4'b1111, 32'h13);
    chk("R8 request", {31'h0, reset_req_o}, 32'h1);
    rd(3'd5, 32'h2, "R8 status");
    wr(3'd5, 4'b1111, 32'h0);
    rd(3'd5, 32'h2, "R8 kept");
    // R9 soft reset
    wr(3'd3, 4'b0001, 32'h10);
    @(negedge clk); rst_n = 0;
    idle(2);
    rst_n = 1;
    rd(3'd0, 32'h0, "R9 soft cfg");
    rd(3'd1, 32'hC3, "R9 soft diag kept");
    rd(3'd2, 32'h0, "R9 soft mdm");
    rd(3'd3, 32'h0, "R9 soft aux");
    rd(3'd4, 32'h0, "R9 soft pwr");
    rd(3'd5, 32'h2, "R9 soft sys kept");
    // R9 power-on reset
    @(negedge clk); por_n = 0;
    idle(2);
    por_n = 1;
    rd(3'd1, 32'h0, "R9 por diag clear");
    rd(3'd5, 32'h0, "R9 por sys clear");
    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule